// File: doc/BRIEF.md
# DSP Control Register Bank

This block keeps the two 8-bit control registers of an audio signal-processing core and turns their bits into the gating signals and strobes the core needs. The first register, the run-control register, is double-buffered. A host write fills a staging copy, and that copy becomes the active value only when a frame sync pulse arrives while a write is pending. A sync pulse with nothing pending leaves the active value alone. The second register, the memory-mode register, takes a host write on the next clock edge. Host reads always return the active contents.

From the run-control register the block derives several outputs:
- mute gating for two serial inputs and three serial outputs;
- a standby line for the external RAM;
- a NOP-force signal while a program is loading;
- a break request, qualified by a loaded break address;
- one-cycle reset pulses for the interrupt-ignore flag and the refresh-ignore flag when program loading ends;
- a RAM-clear request that clears its own trigger bit once the clear sequencer reports that clearing has started.

The memory-mode bits are driven out unchanged.

Three small state machines do the work:
- **Staging machine**: states `STG_EMPTY` and `STG_PENDING`. The transition `write` goes from EMPTY to PENDING. The transition `latch` goes from PENDING to EMPTY and happens on a sync pulse with no write in the same cycle.
- **Clear machine**: states `CLR_IDLE` and `CLR_ARMED`. The transition `arm` goes from IDLE to ARMED when the trigger bit is 1. The transition `ack` goes from ARMED to IDLE when the sequencer reports that clearing has started.
- **Program-load machine**: states `PL_LOADING` and `PL_RUNNING`. The transition `finish` goes from LOADING to RUNNING when the load bit reads 1. The transition `reload` goes from RUNNING to LOADING when the load bit reads 0.

Top module: `dsp_ctrl_regs`

## Requirements
- R1: After reset the run-control register reads 8'h3D and the memory-mode register reads 8'h00.
- R2: A host write to address 0 does not change the read value or the outputs until a sync pulse arrives while a write is pending. The staged byte becomes active on that sync edge. A sync pulse with no pending write changes nothing.
- R3: A host write to address 1 takes effect on the next edge. Bit 3 of the memory-mode register always reads 0.
- R4: Run-control bit 5 set forces both serial inputs to 0. Bits 2, 3 and 4 each force serial output 0, 1 and 2 to 0 respectively.
- R5: The RAM standby output is run-control bit 0 OR memory-mode bit 7.
- R6: The NOP-force output is high exactly while run-control bit 7 is 0.
- R7: In the first cycle that run-control bit 7 reads 1 after having read 0, both flag-reset outputs pulse high for exactly one cycle.
- R8: The break request output is run-control bit 6 AND the break-address-loaded input.
- R9: When run-control bit 1 reads 1, the clear request rises one cycle later. When the clear request is high and clear-started is seen, the request drops and bit 1 reads 0 on the next cycle, unless a sync load happens on the same edge, in which case the load wins.
- R10: Memory-mode bits drive the mode outputs:
  - bit 7: program-counter output select;
  - bit 6: rewrite enable;
  - bit 5: 512fs clock select;
  - bit 4: DRAM select;
  - bit 2: 32-bit bus select;
  - bit 1: 8-bit access select;
  - bit 0: RAM partition enable.
- R11: If a write to address 0 and a sync pulse fall in the same cycle while a write is pending, the older staged byte becomes active and the new byte stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | Register select for read and write (0 run-control, 1 memory-mode) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Active contents of the selected register |
| sync_pulse | input | 1 | Frame sync; latches a pending run-control write |
| clr_started | input | 1 | Clear sequencer reports clearing has begun |
| brk_addr_valid | input | 1 | A break address has been loaded |
| sdi_in | input | NUM_SDI | Serial input lanes before gating |
| sdo_in | input | NUM_SDO | Serial output lanes before gating |
| sdi_out | output | NUM_SDI | Gated serial inputs |
| sdo_out | output | NUM_SDO | Gated serial outputs |
| ram_standby | output | 1 | External RAM standby |
| ram_clear_req | output | 1 | Request to clear the delay domain |
| nop_force | output | 1 | Force core instructions to NOP |
| break_req | output | 1 | Break request to the core |
| irq_ign_clr | output | 1 | Reset pulse for the interrupt-ignore flag |
| rfsh_ign_clr | output | 1 | Reset pulse for the refresh-ignore flag |
| pc_out_sel | output | 1 | Program counter onto shared IO pins |
| rewrite_en | output | 1 | Coincidence rewrite enable |
| clk_sel_512 | output | 1 | 1 selects 512fs, 0 selects 640fs |
| ram_is_dram | output | 1 | 1 selects DRAM, 0 selects PSRAM |
| bus_32 | output | 1 | 1 selects 32-bit bus, 0 selects 16-bit bus |
| access_8 | output | 1 | 1 selects 8-bit access, 0 selects 16-bit access |
| ram_partition | output | 1 | External RAM partition enable |

## Verification
On every cycle, the assertions check four things:
- the active run-control value holds still unless a sync load or a clear acknowledgement occurs;
- a pending byte is copied exactly on a sync edge;
- the clear request and its trigger bit both fall after an acknowledgement;
- each flag-reset pulse lasts one cycle and never coincides with NOP forcing.

Three behaviours only show up in the bench's scenarios, which compare against a cycle model:
- the exact reset values;
- the same-cycle write-and-sync ordering;
- the mute lane mapping and the mode bit positions.

// File: rtl/dsp_ctrl_pkg.sv
package dsp_ctrl_pkg;
    localparam int REG_W = 8;

    localparam logic [REG_W-1:0] RUN_RST  = 8'h3D;
    localparam logic [REG_W-1:0] MODE_RST = 8'h00;
    localparam logic [REG_W-1:0] MODE_MASK = 8'hF7;

    // run-control bit positions
    localparam int RB_PLOAD   = 7;
    localparam int RB_BREAK   = 6;
    localparam int RB_INMUTE  = 5;
    localparam int RB_OMUTE0  = 2;
    localparam int RB_CLEAR   = 1;
    localparam int RB_STANDBY = 0;

    // memory-mode bit positions
    localparam int MB_PCOUT = 7;
    localparam int MB_REWR  = 6;
    localparam int MB_CK512 = 5;
    localparam int MB_DRAM  = 4;
    localparam int MB_BUS32 = 2;
    localparam int MB_ACC8  = 1;
    localparam int MB_PART  = 0;

    typedef enum logic {STG_EMPTY, STG_PENDING} stage_e;
    typedef enum logic {CLR_IDLE, CLR_ARMED} clr_e;
    typedef enum logic {PL_LOADING, PL_RUNNING} pload_e;
endpackage

// File: rtl/dcr_run_stage.sv
module dcr_run_stage
    import dsp_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             sync_pulse,
    input  logic             clr_ack,
    output logic [REG_W-1:0] active
);
    stage_e           st_q, st_d;
    logic [REG_W-1:0] staged_q;
    logic [REG_W-1:0] active_q;
    logic             load;

    assign load = (st_q == STG_PENDING) && sync_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STG_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            STG_EMPTY:   if (wr_en) st_d = STG_PENDING;
            STG_PENDING: if (sync_pulse && !wr_en) st_d = STG_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     staged_q <= RUN_RST;
        else if (wr_en) staged_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       active_q <= RUN_RST;
        else if (load)    active_q <= staged_q;
        else if (clr_ack) active_q[RB_CLEAR] <= 1'b0;
    end

    assign active = active_q;

    assert_hold_without_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && !clr_ack) |=> $stable(active_q));

    assert_load_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == STG_PENDING && sync_pulse) |=> (active_q == $past(staged_q)));

    assert_trigger_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ack && !load) |=> !active_q[RB_CLEAR]);
endmodule

// File: rtl/dcr_clear_fsm.sv
module dcr_clear_fsm
    import dsp_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic clr_started,
    output logic clear_req,
    output logic clr_ack
);
    clr_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CLR_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CLR_IDLE:  if (trigger) st_d = CLR_ARMED;
            CLR_ARMED: if (clr_started) st_d = CLR_IDLE;
        endcase
    end

    always_comb begin
        clear_req = 1'b0;
        clr_ack   = 1'b0;
        unique case (st_q)
            CLR_IDLE:  ;
            CLR_ARMED: begin
                clear_req = 1'b1;
                clr_ack   = clr_started;
            end
        endcase
    end

    assert_req_drops_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ack |=> !clear_req);

    assert_req_needs_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear_req) |-> $past(trigger));
endmodule

// File: rtl/dcr_pload_fsm.sv
module dcr_pload_fsm
    import dsp_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pload_off,
    output logic flag_pulse
);
    pload_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PL_LOADING;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PL_LOADING: if (pload_off)  st_d = PL_RUNNING;
            PL_RUNNING: if (!pload_off) st_d = PL_LOADING;
        endcase
    end

    always_comb begin
        flag_pulse = 1'b0;
        unique case (st_q)
            PL_LOADING: flag_pulse = pload_off;
            PL_RUNNING: flag_pulse = 1'b0;
        endcase
    end

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pulse |=> !flag_pulse);
endmodule

// File: rtl/dcr_gate.sv
module dcr_gate
    import dsp_ctrl_pkg::*;
#(
    parameter int NUM_SDI = 2,
    parameter int NUM_SDO = 3
) (
    input  logic [REG_W-1:0]   run_reg,
    input  logic               mode_pcout,
    input  logic               brk_addr_valid,
    input  logic [NUM_SDI-1:0] sdi_in,
    input  logic [NUM_SDO-1:0] sdo_in,
    output logic [NUM_SDI-1:0] sdi_out,
    output logic [NUM_SDO-1:0] sdo_out,
    output logic               ram_standby,
    output logic               nop_force,
    output logic               break_req
);
    for (genvar i = 0; i < NUM_SDI; i++) begin : g_sdi
        assign sdi_out[i] = sdi_in[i] & ~run_reg[RB_INMUTE];
    end

    for (genvar k = 0; k < NUM_SDO; k++) begin : g_sdo
        assign sdo_out[k] = sdo_in[k] & ~run_reg[RB_OMUTE0 + k];
    end

    assign ram_standby = run_reg[RB_STANDBY] | mode_pcout;
    assign nop_force   = ~run_reg[RB_PLOAD];
    assign break_req   = run_reg[RB_BREAK] & brk_addr_valid;
endmodule

// File: rtl/dsp_ctrl_regs.sv
module dsp_ctrl_regs
    import dsp_ctrl_pkg::*;
#(
    parameter int NUM_SDI = 2,
    parameter int NUM_SDO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               sync_pulse,
    input  logic               clr_started,
    input  logic               brk_addr_valid,
    input  logic [NUM_SDI-1:0] sdi_in,
    input  logic [NUM_SDO-1:0] sdo_in,
    output logic [NUM_SDI-1:0] sdi_out,
    output logic [NUM_SDO-1:0] sdo_out,
    output logic               ram_standby,
    output logic               ram_clear_req,
    output logic               nop_force,
    output logic               break_req,
    output logic               irq_ign_clr,
    output logic               rfsh_ign_clr,
    output logic               pc_out_sel,
    output logic               rewrite_en,
    output logic               clk_sel_512,
    output logic               ram_is_dram,
    output logic               bus_32,
    output logic               access_8,
    output logic               ram_partition
);
    logic [REG_W-1:0] run_reg;
    logic [REG_W-1:0] mode_q;
    logic             clr_ack;
    logic             flag_pulse;

    dcr_run_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr && !host_addr),
        .wdata      (host_wdata),
        .sync_pulse (sync_pulse),
        .clr_ack    (clr_ack),
        .active     (run_reg)
    );

    dcr_clear_fsm u_clear (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (run_reg[RB_CLEAR]),
        .clr_started (clr_started),
        .clear_req   (ram_clear_req),
        .clr_ack     (clr_ack)
    );

    dcr_pload_fsm u_pload (
        .clk        (clk),
        .rst_n      (rst_n),
        .pload_off  (run_reg[RB_PLOAD]),
        .flag_pulse (flag_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     mode_q <= MODE_RST;
        else if (host_wr && host_addr)  mode_q <= host_wdata & MODE_MASK;
    end

    dcr_gate #(.NUM_SDI(NUM_SDI), .NUM_SDO(NUM_SDO)) u_gate (
        .run_reg        (run_reg),
        .mode_pcout     (mode_q[MB_PCOUT]),
        .brk_addr_valid (brk_addr_valid),
        .sdi_in         (sdi_in),
        .sdo_in         (sdo_in),
        .sdi_out        (sdi_out),
        .sdo_out        (sdo_out),
        .ram_standby    (ram_standby),
        .nop_force      (nop_force),
        .break_req      (break_req)
    );

    assign host_rdata    = host_addr ? mode_q : run_reg;
    assign irq_ign_clr   = flag_pulse;
    assign rfsh_ign_clr  = flag_pulse;
    assign pc_out_sel    = mode_q[MB_PCOUT];
    assign rewrite_en    = mode_q[MB_REWR];
    assign clk_sel_512   = mode_q[MB_CK512];
    assign ram_is_dram   = mode_q[MB_DRAM];
    assign bus_32        = mode_q[MB_BUS32];
    assign access_8      = mode_q[MB_ACC8];
    assign ram_partition = mode_q[MB_PART];

    assert_pulse_not_loading_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ign_clr |-> !nop_force);

    assert_mode_spare_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr) |=> !(host_addr && host_rdata[3]) || !host_addr);
endmodule

// File: tb/dsp_ctrl_regs_test.sv
module dsp_ctrl_regs_test;
    localparam int NSDI = 2;
    localparam int NSDO = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_addr = 1'b0, sync_pulse = 1'b0;
    logic clr_started = 1'b0, brk_addr_valid = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [NSDI-1:0] sdi_in = '0;
    logic [NSDO-1:0] sdo_in = '0;
    logic [7:0] host_rdata;
    logic [NSDI-1:0] sdi_out;
    logic [NSDO-1:0] sdo_out;
    logic ram_standby, ram_clear_req, nop_force, break_req, irq_ign_clr, rfsh_ign_clr;
    logic pc_out_sel, rewrite_en, clk_sel_512, ram_is_dram, bus_32, access_8, ram_partition;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_act = 8'h3D, m_stg = 8'h3D, m_mode = 8'h00;
    bit m_pend = 0, m_armed = 0, m_prev7 = 0, m_same = 0;

    always #2.5 clk = ~clk;

    dsp_ctrl_regs #(.NUM_SDI(NSDI), .NUM_SDO(NSDO)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sync_pulse(sync_pulse),
        .clr_started(clr_started), .brk_addr_valid(brk_addr_valid),
        .sdi_in(sdi_in), .sdo_in(sdo_in), .sdi_out(sdi_out), .sdo_out(sdo_out),
        .ram_standby(ram_standby), .ram_clear_req(ram_clear_req), .nop_force(nop_force),
        .break_req(break_req), .irq_ign_clr(irq_ign_clr), .rfsh_ign_clr(rfsh_ign_clr),
        .pc_out_sel(pc_out_sel), .rewrite_en(rewrite_en), .clk_sel_512(clk_sel_512),
        .ram_is_dram(ram_is_dram), .bus_32(bus_32), .access_8(access_8),
        .ram_partition(ram_partition)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_sdo(input logic [2:0] d, input logic [7:0] r);
        return d & ~r[4:2];
    endfunction

    function automatic logic [6:0] exp_modes(input logic [7:0] m);
        return {m[7], m[6], m[5], m[4], m[2], m[1], m[0]};
    endfunction

    task automatic compare_all();
        check(m_same ? "R11 rdata" : (host_addr ? "R3 rdata" : "R2 rdata"),
              host_rdata, host_addr ? m_mode : m_act);
        check("R4 sdi", {6'd0, sdi_out}, {6'd0, sdi_in & {NSDI{~m_act[5]}}});
        check("R4 sdo", {5'd0, sdo_out}, {5'd0, exp_sdo(sdo_in, m_act)});
        check("R5 standby", {7'd0, ram_standby}, {7'd0, m_act[0] | m_mode[7]});
        check("R6 nop", {7'd0, nop_force}, {7'd0, ~m_act[7]});
        check("R7 pulses", {6'd0, irq_ign_clr, rfsh_ign_clr},
              {6'd0, {2{m_act[7] & ~m_prev7}}});
        check("R8 break", {7'd0, break_req}, {7'd0, m_act[6] & brk_addr_valid});
        check("R9 clear_req", {7'd0, ram_clear_req}, {7'd0, m_armed});
        check("R10 modes", {1'b0, pc_out_sel, rewrite_en, clk_sel_512, ram_is_dram,
              bus_32, access_8, ram_partition}, {1'b0, exp_modes(m_mode)});
    endtask

    task automatic model_edge();
        bit ack, load, wr0;
        ack  = m_armed && clr_started;
        load = m_pend && sync_pulse;
        wr0  = host_wr && !host_addr;
        m_same  = load && wr0;
        m_prev7 = m_act[7];
        m_armed = m_armed ? !clr_started : m_act[1];
        if (load)     m_act = m_stg;
        else if (ack) m_act[1] = 1'b0;
        if (wr0) begin m_stg = host_wdata; m_pend = 1; end
        else if (load) m_pend = 0;
        if (host_wr && host_addr) m_mode = host_wdata & 8'hF7;
    endtask

    task automatic step(input bit wr, input bit a, input logic [7:0] wd, input bit sy,
                        input bit cs, input bit bv, input logic [NSDI-1:0] si,
                        input logic [NSDO-1:0] so);
        host_wr = wr; host_addr = a; host_wdata = wd; sync_pulse = sy;
        clr_started = cs; brk_addr_valid = bv; sdi_in = si; sdo_in = so;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        sdi_in = '1; sdo_in = '1;
        repeat (3) @(negedge clk);
        // R1 reset values, both registers
        check("R1 run reset", host_rdata, 8'h3D);
        host_addr = 1'b1; #1;
        check("R1 mode reset", host_rdata, 8'h00);
        check("R1 standby", {7'd0, ram_standby}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        // R2 staged write invisible, sync without pending does nothing
        step(1, 0, 8'hC2, 0, 0, 1, '1, '1);
        check("R2 staged hidden", host_rdata, 8'h3D);
        step(0, 0, 8'h00, 0, 0, 1, '1, '1);
        step(0, 0, 8'h00, 1, 0, 1, '1, '1);
        check("R2 latched", host_rdata, 8'hC2);
        check("R7 pulse on end of load", {7'd0, irq_ign_clr}, 8'd1);
        step(0, 0, 8'h00, 1, 0, 1, '1, '1);
        check("R2 sync no pending", host_rdata, 8'hC2);
        // R9 clear trigger held until started, then self-clears
        step(0, 0, 8'h00, 0, 0, 1, '1, '1);
        check("R9 armed", {7'd0, ram_clear_req}, 8'd1);
        step(0, 0, 8'h00, 0, 1, 1, '1, '1);
        check("R9 self-cleared", host_rdata, 8'hC0);
        // R11 write and sync same cycle with pending
        step(1, 0, 8'h81, 0, 0, 0, '1, '1);
        step(1, 0, 8'h7E, 1, 0, 0, '1, '1);
        check("R11 older byte active", host_rdata, 8'h81);
        step(0, 0, 8'h00, 1, 0, 0, '1, '1);
        check("R11 newer byte follows", host_rdata, 8'h7E);
        // R3 spare bit
        step(1, 1, 8'hFF, 0, 0, 0, '1, '1);
        check("R3 spare reads zero", host_rdata, 8'hF7);
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit wr, a, sy, cs, bv;
            logic [7:0] wd;
            wr = ($urandom % 4) == 0;
            a  = $urandom % 2;
            sy = ($urandom % 4) == 0;
            cs = ($urandom % 3) == 0;
            bv = $urandom % 2;
            wd = 8'($urandom);
            step(wr, a, wd, sy, cs, bv, NSDI'($urandom), NSDO'($urandom));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule